// File: doc/BRIEF.md
# Speed-Compensated Vector Stepper

This block traces one straight vector on a beam display by stepping an X and a Y position counter whose outputs feed the deflection DACs. An error accumulator chooses, on every step, whether only the major axis moves or both axes move. Moving both axes gives a diagonal step.

A host first writes its configuration registers through a simple write port:
- the two error increments,
- the start point,
- the initial error value,
- the axis mode bits.

It then writes the length register, and that write starts the vector. Steps are paced by a clock-enable divider in the system clock domain. A single-axis step lasts five clocks. A diagonal step lasts seven clocks, so the beam travels at nearly the same speed along every step.

While a vector is drawing, the block holds `busy` high and drops every host write. When the last step completes, it raises `done` for one clock.

Top module: `vector_stepper`

## Requirements
- R1: After reset the position outputs are 0, `busy` and `done` are low, and every configuration register is 0.
- R2: When idle, a write to address 0 loads `wr_data[9:0]` into X and a write to address 1 loads it into Y. The new value appears on the output one clock later.
- R3: When idle, a write to address 6 loads length L from `wr_data[11:0]` and raises `busy` on the next clock. Exactly L+1 steps follow, and the internal length count drops by one per step.
- R4: The mode register at address 5 has bit0 = X is major, bit1 = Y is major, bit2 = X counts down, bit3 = Y counts down. A major axis moves one count on every step.
- R5: A non-major axis moves only on steps where the signed 12-bit error, loaded at address 4, is negative. Otherwise it holds.
- R6: On each step the error gains the increment at address 2 when it is non-negative, or the increment at address 3 when it is negative. The sum wraps at 12 bits.
- R7: A step whose starting error is negative lasts 7 clocks, and otherwise 5 clocks. The first step ends 5 or 7 clocks after the length write is captured.
- R8: `done` is high for exactly one clock, in the first clock in which `busy` is low after a draw.
- R9: While `busy` is high, writes to every address, including the length, are ignored. This holds for a write captured in the same clock as the final step.
- R10: Position counters are 10 bits and wrap modulo 1024 in both directions.
- R11: With both increments at zero, a negative initial error gives only diagonal steps, and a non-negative one gives only major-axis steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0 X, 1 Y, 2 inc non-neg, 3 inc neg, 4 error, 5 mode, 6 length) |
| wr_data | input | 16 | Write data |
| x_pos | output | 10 | X beam position to DAC |
| y_pos | output | 10 | Y beam position to DAC |
| busy | output | 1 | Vector in progress |
| done | output | 1 | One-clock pulse at vector end |

## Verification
The host write port and the final step of a vector can act in the same clock. A length write that arrives together with the last step must be dropped, because `busy` is still high when it is sampled.

The bench computes from the requirements the exact clock in which the last step occurs and places a length write there. In the next clock it expects `busy` low, `done` high and the final position unchanged by the write. A fresh write one clock later must start a new vector.

A near-exhaustive sweep covers:
- the mode bits,
- the signs of the initial error,
- the increment pairs,
- the lengths.

For each vector the sweep compares the final position and the total duration against arithmetic expectations.

// File: rtl/vs_pkg.sv
package vs_pkg;

   typedef enum logic [2:0] {
      REG_X_START = 3'd0,
      REG_Y_START = 3'd1,
      REG_INC_NN  = 3'd2,
      REG_INC_NEG = 3'd3,
      REG_ERR     = 3'd4,
      REG_MODE    = 3'd5,
      REG_LENGTH  = 3'd6
   } vs_reg_e;

   typedef struct packed {
      logic y_down;
      logic x_down;
      logic y_major;
      logic x_major;
   } vs_mode_t;

   localparam int NUM_AXES = 2;

endpackage

// File: rtl/vs_regs.sv
module vs_regs
   import vs_pkg::*;
#(
   parameter int ERR_W  = 12,
   parameter int DATA_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [2:0]              wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    busy,
   output logic                    accept,
   output logic [ERR_W-1:0]        inc_nn,
   output logic [ERR_W-1:0]        inc_neg,
   output vs_mode_t                mode
);

   assign accept = wr_en && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inc_nn  <= '0;
         inc_neg <= '0;
         mode    <= '0;
      end else if (accept) begin
         case (wr_addr)
            REG_INC_NN:  inc_nn  <= wr_data[ERR_W-1:0];
            REG_INC_NEG: inc_neg <= wr_data[ERR_W-1:0];
            REG_MODE:    mode    <= vs_mode_t'(wr_data[3:0]);
            default:     ;
         endcase
      end
   end

   // Configuration is frozen for the whole draw.
   assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(inc_nn) && $stable(inc_neg) && $stable(mode));

endmodule

// File: rtl/vs_step_timer.sv
module vs_step_timer #(
   parameter int DIV_AXIS   = 5,
   parameter int DIV_DIAG   = 7,
   parameter bit SPEED_COMP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   input  logic neg,
   output logic step
);

   localparam int DIV_MAX = (DIV_DIAG > DIV_AXIS) ? DIV_DIAG : DIV_AXIS;
   localparam int PH_W    = $clog2(DIV_MAX);

   logic [PH_W-1:0] phase;
   logic [PH_W-1:0] limit;

   generate
      if (SPEED_COMP) begin : g_comp
         assign limit = neg ? PH_W'(DIV_DIAG - 1) : PH_W'(DIV_AXIS - 1);
      end else begin : g_flat
         assign limit = PH_W'(DIV_AXIS - 1);
      end
   endgenerate

   assign step = busy && (phase == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               phase <= '0;
      else if (start || step)   phase <= '0;
      else if (busy)            phase <= phase + 1'b1;
   end

   assert_phase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> phase <= PH_W'(DIV_MAX - 1));

endmodule

// File: rtl/vs_err_accum.sv
module vs_err_accum #(
   parameter int ERR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ERR_W-1:0] load_val,
   input  logic             step,
   input  logic [ERR_W-1:0] inc_nn,
   input  logic [ERR_W-1:0] inc_neg,
   output logic             neg
);

   logic [ERR_W-1:0] err_q;
   logic [ERR_W-1:0] addend;
   logic [ERR_W-1:0] sum;

   assign neg    = err_q[ERR_W-1];
   assign addend = neg ? inc_neg : inc_nn;
   assign sum    = err_q + addend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     err_q <= '0;
      else if (load)  err_q <= load_val;
      else if (step)  err_q <= sum;
   end

   // Between steps the error value holds.
   assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !load |=> $stable(err_q));

endmodule

// File: rtl/vs_axis.sv
module vs_axis #(
   parameter int POS_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [POS_W-1:0] load_val,
   input  logic             step,
   input  logic             neg,
   input  logic             major,
   input  logic             down,
   output logic [POS_W-1:0] pos
);

   logic move;
   assign move = step && (major || neg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pos <= '0;
      else if (load)   pos <= load_val;
      else if (move)   pos <= down ? pos - 1'b1 : pos + 1'b1;
   end

   assert_major_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      step && major |=> pos != $past(pos));

   assert_minor_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step && !major && !neg && !load |=> $stable(pos));

endmodule

// File: rtl/vector_stepper.sv
module vector_stepper
   import vs_pkg::*;
#(
   parameter int POS_W      = 10,
   parameter int ERR_W      = 12,
   parameter int LEN_W      = 12,
   parameter int DATA_W     = 16,
   parameter int DIV_AXIS   = 5,
   parameter int DIV_DIAG   = 7,
   parameter bit SPEED_COMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [POS_W-1:0]  x_pos,
   output logic [POS_W-1:0]  y_pos,
   output logic              busy,
   output logic              done
);

   localparam int GAP_W = $clog2(DIV_DIAG + DIV_AXIS) + 1;

   generate
      if (POS_W < 2 || POS_W > DATA_W)  begin : g_bad_pos  $error("POS_W out of range");  end
      if (ERR_W < 2 || ERR_W > DATA_W)  begin : g_bad_err  $error("ERR_W out of range");  end
      if (LEN_W < 1 || LEN_W > DATA_W)  begin : g_bad_len  $error("LEN_W out of range");  end
      if (DIV_AXIS < 2)                 begin : g_bad_div  $error("DIV_AXIS too small"); end
      if (SPEED_COMP && DIV_DIAG <= DIV_AXIS) begin : g_bad_ratio
         $error("DIV_DIAG must exceed DIV_AXIS");
      end
   endgenerate

   logic             accept;
   logic [ERR_W-1:0] inc_nn;
   logic [ERR_W-1:0] inc_neg;
   vs_mode_t         mode;
   logic             start;
   logic             err_load;
   logic             step;
   logic             neg;
   logic [LEN_W:0]   len_q;

   vs_regs #(.ERR_W(ERR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .accept(accept), .inc_nn(inc_nn), .inc_neg(inc_neg), .mode(mode)
   );

   assign start    = accept && (wr_addr == REG_LENGTH);
   assign err_load = accept && (wr_addr == REG_ERR);

   // Length counter: idle while the top bit is set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= '1;
      else if (start)  len_q <= {1'b0, wr_data[LEN_W-1:0]};
      else if (step)   len_q <= len_q - 1'b1;
   end

   assign busy = !len_q[LEN_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= step && (len_q == '0);
   end

   vs_step_timer #(.DIV_AXIS(DIV_AXIS), .DIV_DIAG(DIV_DIAG), .SPEED_COMP(SPEED_COMP)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .neg(neg), .step(step)
   );

   vs_err_accum #(.ERR_W(ERR_W)) u_err (
      .clk(clk), .rst_n(rst_n), .load(err_load), .load_val(wr_data[ERR_W-1:0]),
      .step(step), .inc_nn(inc_nn), .inc_neg(inc_neg), .neg(neg)
   );

   logic [POS_W-1:0] pos_w [NUM_AXES];

   generate
      for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
         logic ld;
         logic maj;
         logic dn;
         assign ld  = accept && (wr_addr == ((a == 0) ? REG_X_START : REG_Y_START));
         assign maj = (a == 0) ? mode.x_major : mode.y_major;
         assign dn  = (a == 0) ? mode.x_down  : mode.y_down;
         vs_axis #(.POS_W(POS_W)) u_axis (
            .clk(clk), .rst_n(rst_n), .load(ld), .load_val(wr_data[POS_W-1:0]),
            .step(step), .neg(neg), .major(maj), .down(dn), .pos(pos_w[a])
         );
      end
   endgenerate

   assign x_pos = pos_w[0];
   assign y_pos = pos_w[1];

   // Checker-side count of clocks since the draw start or the previous step.
   logic [GAP_W-1:0] gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gap <= '0;
      else if (start || step)  gap <= '0;
      else if (busy)           gap <= gap + 1'b1;
   end

   generate
      if (SPEED_COMP) begin : g_gap_chk
         assert_step_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            step |-> gap == (neg ? GAP_W'(DIV_DIAG - 1) : GAP_W'(DIV_AXIS - 1)));
      end
   endgenerate

   assert_len_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> len_q == $past(len_q) - 1'b1);

   assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_en |=> !(busy && $past(len_q) != len_q && !$past(step)));

endmodule

// File: tb/tb_vector_stepper.sv
module tb_vector_stepper;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [9:0]  x_pos, y_pos;
   logic        busy, done;
   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vector_stepper dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .x_pos(x_pos), .y_pos(y_pos), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Arithmetic expectation derived from the requirements.
   task automatic model(input int x0, input int y0, input int e0, input int ip, input int ineg,
                        input bit xm, input bit ym, input bit xd, input bit yd, input int len,
                        output int xe, output int ye, output int te);
      logic [11:0] e;
      logic [11:0] a;
      e = e0[11:0];
      xe = x0; ye = y0; te = 0;
      for (int s = 0; s <= len; s++) begin
         bit n;
         n = e[11];
         te += n ? 7 : 5;
         if (xm || n) xe = (xd ? xe - 1 : xe + 1) & 1023;
         if (ym || n) ye = (yd ? ye - 1 : ye + 1) & 1023;
         a = n ? ineg[11:0] : ip[11:0];
         e = e + a;
      end
   endtask

   task automatic configure(input int x0, input int y0, input int e0, input int ip, input int ineg,
                            input bit xm, input bit ym, input bit xd, input bit yd);
      wr(0, x0); wr(1, y0); wr(2, ip); wr(3, ineg); wr(4, e0);
      wr(5, {28'd0, yd, xd, ym, xm});
   endtask

   // Starts a draw and waits for done; returns clocks seen.
   task automatic draw(input int len, output int cyc);
      wr(6, len);
      cyc = 1;
      chk(busy === 1'b1, "R3 busy after length write", int'(busy), 1);
      while (done !== 1'b1 && cyc < 4000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int xe, ye, te, cyc;
      int incs_p [3] = '{0, -4, -7};
      int incs_n [3] = '{0, 6, 3};
      int lens   [4] = '{0, 1, 5, 13};
      int e0s    [2] = '{-3, 2};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(x_pos == 10'd0, "R1 x after reset", int'(x_pos), 0);
      chk(y_pos == 10'd0, "R1 y after reset", int'(y_pos), 0);
      chk(busy == 1'b0,   "R1 busy after reset", int'(busy), 0);
      chk(done == 1'b0,   "R1 done after reset", int'(done), 0);
      // R2 position load
      wr(0, 321);
      chk(x_pos == 10'd321, "R2 x load", int'(x_pos), 321);
      wr(1, 77);
      chk(y_pos == 10'd77, "R2 y load", int'(y_pos), 77);

      // Near-exhaustive sweep
      for (int mm = 0; mm < 3; mm++) begin
         for (int dd = 0; dd < 4; dd++) begin
            for (int es = 0; es < 2; es++) begin
               for (int ii = 0; ii < 3; ii++) begin
                  for (int ll = 0; ll < 4; ll++) begin
                     bit xm, ym, xd, yd;
                     int x0, y0;
                     xm = (mm != 1); ym = (mm != 0);
                     xd = dd[0]; yd = dd[1];
                     x0 = xd ? 2 : 1021;
                     y0 = yd ? 3 : 1020;
                     configure(x0, y0, e0s[es], incs_p[ii], incs_n[ii], xm, ym, xd, yd);
                     model(x0, y0, e0s[es], incs_p[ii], incs_n[ii], xm, ym, xd, yd, lens[ll],
                           xe, ye, te);
                     draw(lens[ll], cyc);
                     chk(x_pos == xe[9:0], "R4 R5 R6 R10 R11 final x", int'(x_pos), xe);
                     chk(y_pos == ye[9:0], "R4 R5 R6 R10 R11 final y", int'(y_pos), ye);
                     chk(cyc == te + 1, "R3 R7 draw duration", cyc, te + 1);
                     chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
                     @(negedge clk);
                     chk(done == 1'b0, "R8 done one clock", int'(done), 0);
                  end
               end
            end
         end
      end

      // R9 writes during busy are dropped
      configure(100, 200, -1, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
      wr(6, 3);
      wr(0, 500); wr(3, 5); wr(5, 4'b1110); wr(6, 50); wr(4, 7);
      cyc = 11;
      while (done !== 1'b1 && cyc < 4000) begin @(negedge clk); cyc++; end
      chk(cyc == 29, "R9 R11 duration unchanged by busy writes", cyc, 29);
      chk(x_pos == 10'd104, "R9 x unchanged by busy writes", int'(x_pos), 104);
      chk(y_pos == 10'd204, "R9 y unchanged by busy writes", int'(y_pos), 204);

      // R9 length write in the same clock as the final step
      configure(10, 10, 0, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
      wr(6, 2);
      cyc = 1;
      while (cyc < 15) begin @(negedge clk); cyc++; end
      wr_en = 1'b1; wr_addr = 3'd6; wr_data = 16'd4;
      @(negedge clk);
      wr_en = 1'b0;
      chk(done == 1'b1, "R8 done at final step", int'(done), 1);
      chk(busy == 1'b0, "R9 same-clock length write dropped", int'(busy), 0);
      chk(x_pos == 10'd13, "R9 final x after same-clock write", int'(x_pos), 13);
      @(negedge clk);
      chk(busy == 1'b0, "R9 still idle", int'(busy), 0);
      wr(6, 0);
      chk(busy == 1'b1, "R3 restart after idle", int'(busy), 1);
      repeat (8) @(negedge clk);
      chk(x_pos == 10'd14, "R4 single step with length zero", int'(x_pos), 14);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule